// File: doc/BRIEF.md
# Decade Counter and Divide-by-Ten Generator

This block is a four-bit counter that steps through ten states on enabled clock edges and then wraps. It is also a divide-by-ten clock generator. Every storage bit runs on the single block clock and changes on the same edge, so no stage waits for another to settle. Wrap detection is synchronous: the next state is forced to zero on the edge that would otherwise produce the first illegal value. No transient out-of-range state ever appears.

Two structures are available, and the choice is latched from `symMode` while reset is held. In decade structure the four bits form a plain BCD counter. It runs 0 through 9, and its top bit serves as the divided output, which is high for only two of every ten edges. In symmetric structure the three low bits form a modulo-5 counter, and the top bit is a toggle stage that flips whenever that counter wraps. The divided output is then high for five edges and low for five. A terminal-count flag marks the last state of each full ten-edge period.

Top module: `decade_divider`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `count` to 0 and `divOut` to 0, and `symMode` is captured as the structure. Reset takes priority over `en`, and `tc` is 0 during a reset cycle.
- R2: In decade structure (`symMode`=0 at reset), each enabled edge steps `count` 0,1,...,9. After 9 it returns to 0, so values 10 to 15 never appear.
- R3: In decade structure, `divOut` equals bit 3 of `count`. It is high only while `count` is 8 or 9, giving a 2:8 mark-to-space ratio.
- R4: In symmetric structure (`symMode`=1 at reset), bits 2:0 of `count` run 0,1,2,3,4 and then 0 again. Bit 3 of `count` is the toggle stage and is never part of that wrap detection. The visible `count` sequence is therefore 0,1,2,3,4,8,9,10,11,12 and back to 0.
- R5: In symmetric structure, `divOut` equals bit 3 of `count`. It inverts only on the edge where bits 2:0 wrap from 4 to 0, so it is high for exactly 5 enabled edges and low for exactly 5.
- R6: `tc` is 1 in a cycle exactly when `en`=1, `rst`=0, and the counter is at the last state of its ten-edge period. That state is `count`=9 in decade structure and `count`=12 in symmetric structure.
- R7: An edge with `en`=0 and `rst`=0 leaves `count` and `divOut` unchanged, and `tc` is 0 in that cycle.
- R8: A change on `symMode` while `rst` is low has no effect. The structure in use changes only at the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also latches the structure |
| en | input | 1 | Count enable; each enabled edge is one count event |
| symMode | input | 1 | Structure select sampled during reset: 0 decade, 1 symmetric |
| count | output | 4 | Present counter state |
| divOut | output | 1 | Divide-by-ten output (bit 3 of the state) |
| tc | output | 1 | Terminal-count flag for the last state of a ten-edge period |

## Verification
The terminal-count flag and a synchronous reset can fall in the same cycle. The bench drives the counter to its last state (9 in decade structure, 12 in symmetric) and raises `rst` together with `en` in exactly that cycle. It then expects `tc` to stay low and the following state to be zero rather than a normal wrap. The enable gap is also placed on the last state, so that the hold and the wrap meet. A scoreboard model built from the requirements judges every cycle for `count`, `divOut` and `tc`.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;

  // Strobes from control to datapath, valid for the current clock edge
  typedef struct packed {
    logic clear;      // synchronous reset of every bit
    logic advance;    // this edge is a count event
    logic symmetric;  // structure latched at reset: 1 = modulo-5 plus toggle
    logic wrapLow;    // modulo-5 section wraps on this event
    logic wrapFull;   // last state of the ten-event period
  } ctrlStrobes_t;

endpackage

// File: rtl/decdiv_ctrl.sv
module decdiv_ctrl
  import decdiv_pkg::*;
#(
  parameter int SUB_MOD = 5,
  parameter int DEC_MOD = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         symMode,
  input  logic [$clog2(SUB_MOD)-1:0]   lowCnt,
  input  logic                         topBit,
  output ctrlStrobes_t                 strobes,
  output logic                         tc
);

  localparam int LOW_W = $clog2(SUB_MOD);
  localparam int CNT_W = LOW_W + 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(SUB_MOD - 1);
  localparam logic [CNT_W-1:0] DEC_LAST = CNT_W'(DEC_MOD - 1);

  logic modeReg;
  logic atLowLast;
  logic atDecLast;

  // Structure is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) modeReg <= symMode;
  end

  always_comb begin
    atLowLast = (lowCnt == LOW_LAST);
    atDecLast = ({topBit, lowCnt} == DEC_LAST);

    strobes.clear     = rst;
    strobes.advance   = en & ~rst;
    strobes.symmetric = modeReg;
    strobes.wrapLow   = modeReg & atLowLast;
    strobes.wrapFull  = modeReg ? (atLowLast & topBit) : atDecLast;

    tc = strobes.advance & strobes.wrapFull;
  end

  // R6
  tc_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> en);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(modeReg));

endmodule

// File: rtl/decdiv_datapath.sv
module decdiv_datapath
  import decdiv_pkg::*;
#(
  parameter int SUB_MOD = 5,
  parameter int DEC_MOD = 10
) (
  input  logic                         clk,
  input  ctrlStrobes_t                 strobes,
  output logic [$clog2(SUB_MOD)-1:0]   lowCnt,
  output logic                         topBit
);

  localparam int LOW_W = $clog2(SUB_MOD);
  localparam int CNT_W = LOW_W + 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(SUB_MOD - 1);
  localparam logic [CNT_W-1:0] DEC_LAST = CNT_W'(DEC_MOD - 1);

  logic [LOW_W-1:0] lowNext;
  logic [CNT_W-1:0] fullNext;

  always_comb begin
    lowNext  = strobes.wrapLow ? '0 : lowCnt + 1'b1;
    fullNext = strobes.wrapFull ? '0 : {topBit, lowCnt} + 1'b1;
  end

  // All bits share the one clock; wrap is forced to zero synchronously
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      lowCnt <= '0;
      topBit <= 1'b0;
    end else if (strobes.advance) begin
      if (strobes.symmetric) begin
        lowCnt <= lowNext;
        if (strobes.wrapLow) topBit <= ~topBit;
      end else begin
        {topBit, lowCnt} <= fullNext;
      end
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    strobes.clear |=> (lowCnt == '0) && !topBit);

  // R2
  decade_range_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.symmetric |-> ({topBit, lowCnt} <= DEC_LAST));

  // R4
  sub_range_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.symmetric |-> (lowCnt <= LOW_LAST));

  // R5
  toggle_on_wrap_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.symmetric && !$past(strobes.clear) && (topBit != $past(topBit)))
      |-> ($past(lowCnt) == LOW_LAST));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(lowCnt) && $stable(topBit));

endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import decdiv_pkg::*;
#(
  parameter int SUB_MOD = 5,
  parameter int DEC_MOD = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic                             symMode,
  output logic [$clog2(SUB_MOD):0]         count,
  output logic                             divOut,
  output logic                             tc
);

  localparam int LOW_W = $clog2(SUB_MOD);

  ctrlStrobes_t     strobes;
  logic [LOW_W-1:0] lowCnt;
  logic             topBit;

  decdiv_ctrl #(.SUB_MOD(SUB_MOD), .DEC_MOD(DEC_MOD)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .symMode (symMode),
    .lowCnt  (lowCnt),
    .topBit  (topBit),
    .strobes (strobes),
    .tc      (tc)
  );

  decdiv_datapath #(.SUB_MOD(SUB_MOD), .DEC_MOD(DEC_MOD)) uData (
    .clk     (clk),
    .strobes (strobes),
    .lowCnt  (lowCnt),
    .topBit  (topBit)
  );

  assign count  = {topBit, lowCnt};
  assign divOut = topBit;

endmodule

// File: tb/decade_divider_test.sv
module decade_divider_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       symMode = 1'b0;
  logic [3:0] count;
  logic       divOut;
  logic       tc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit         valid;
    logic [3:0] cnt;
    logic       div;
    logic       tcv;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state built from the requirements
  logic [3:0] mCnt = 4'd0;
  bit         mSym = 1'b0;
  bit         mKnown = 1'b0;

  always #4 clk = ~clk;

  decade_divider uut (
    .clk(clk), .rst(rst), .en(en), .symMode(symMode),
    .count(count), .divOut(divOut), .tc(tc)
  );

  function automatic bit atLast(logic [3:0] c, bit s);
    return s ? (c == 4'd12) : (c == 4'd9);
  endfunction

  // Driver: set inputs for the coming edge, push expected outputs for this cycle
  task automatic step(input bit r, input bit e, input bit s, input string req);
    expItem_t it;
    @(negedge clk);
    rst = r; en = e; symMode = s;
    it.valid = mKnown;
    it.cnt   = mCnt;
    it.div   = mCnt[3];
    it.tcv   = e && !r && atLast(mCnt, mSym);
    it.req   = req;
    expQ.push_back(it);
    if (r) begin
      mCnt = 4'd0; mSym = s; mKnown = 1'b1;
    end else if (e) begin
      if (mSym) begin
        if (mCnt[2:0] == 3'd4) mCnt = {~mCnt[3], 3'd0};
        else mCnt = mCnt + 4'd1;
      end else begin
        mCnt = (mCnt == 4'd9) ? 4'd0 : mCnt + 4'd1;
      end
    end
  endtask

  // Monitor: compare in the middle of the low phase, after the inputs settle
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        if (it.valid) begin
          checks++;
          if (count !== it.cnt || divOut !== it.div || tc !== it.tcv) begin
            failures++;
            $display("FAIL %s: count=%0d divOut=%0b tc=%0b expected count=%0d divOut=%0b tc=%0b",
                     it.req, count, divOut, tc, it.cnt, it.div, it.tcv);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, decade structure
    step(1, 0, 0, "R1");
    step(1, 1, 0, "R1");
    // R2 R3 R6: full decade periods
    for (int i = 0; i < 25; i++) step(0, 1, 0, "R2/R3/R6");
    // R7: enable gaps, including a gap on the last state
    for (int i = 0; i < 20; i++) step(0, (i % 3) != 0, 0, "R7");
    while (mCnt != 4'd9) step(0, 1, 0, "R2");
    step(0, 0, 0, "R7");
    step(0, 1, 0, "R6");
    // R1: reset together with enable on the last state
    while (mCnt != 4'd9) step(0, 1, 0, "R2");
    step(1, 1, 0, "R1");
    step(0, 1, 0, "R1");
    // R8: symMode changes without reset
    for (int i = 0; i < 12; i++) step(0, 1, 1, "R8");
    // R1: reset into symmetric structure
    step(1, 1, 1, "R1");
    // R4 R5 R6: symmetric periods
    for (int i = 0; i < 30; i++) step(0, 1, 1, "R4/R5/R6");
    // R7: gaps in symmetric structure
    for (int i = 0; i < 20; i++) step(0, (i % 4) != 1, 1, "R7");
    // R1: reset coinciding with last state 12
    while (mCnt != 4'd12) step(0, 1, 1, "R4");
    step(1, 1, 1, "R1");
    // R8: mode dropped without reset, structure stays symmetric
    for (int i = 0; i < 14; i++) step(0, 1, 0, "R8");
    // R1: back to decade
    step(1, 1, 0, "R1");
    for (int i = 0; i < 11; i++) step(0, 1, 0, "R2");
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule